// File: doc/BRIEF.md
# Tri-State Phase Frequency Detector

This block compares a reference square wave with a feedback square wave, both arriving asynchronously, and produces the control for an external charge-pump loop filter. The two waves are brought into a fast system clock domain through synchronizer chains. A rising edge on either wave is found by comparing the newest synchronized sample with the one before it. Each input has its own state flop, and a rising edge on that input sets it. When both flops would be set at once, both clear together.

The result appears on a single three-state control output, given as a data value and an output-enable. The output drives high while the reference leads and drives low while the feedback leads. It floats, with the enable deasserted, when the two are aligned. Two plain status flags show the state of the two flops.

A rising edge on one input sets its flop even when the other input shows no edge at all. Because of this, a frequency difference drives the output mostly toward the faster input, and the detector can pull the loop in before lock. No data stream passes through the block, so there is no valid/ready handshake. All pins are plain control and status pins.

Top module: `pfd_tristate`

## Requirements
- R1: While the active-low reset is asserted, and in the first cycle after it is released, both status flags and the output-enable are 0.
- R2: When a reference rising edge is detected while the feedback flop is clear and no feedback edge is detected in that cycle, the reference flop is set on the next clock, and the control output drives high (enable 1, data 1).
- R3: When a feedback rising edge is detected while the reference flop is clear and no reference edge is detected in that cycle, the feedback flop is set on the next clock, and the control output drives low (enable 1, data 0).
- R4: When a rising edge is detected on one input while the other input's flop is already set, both flops clear on the next clock, and the output returns to high impedance (enable 0).
- R5: When rising edges are detected on both inputs in the same cycle while both flops are clear, both flops stay clear, and the output stays at high impedance.
- R6: Falling edges and steady levels on either input leave both flops unchanged.
- R7: A rising input level that is present at clock edge k is first reflected on the outputs after clock edge k+SYNC_STAGES, so the total delay is SYNC_STAGES+1 clock edges.
- R8: The two flops are never set at the same time. The enable is 1 exactly when one flop is set, and the data value equals the reference flop.
- R9: A second rising edge on an input whose flop is already set, with no edge on the other input, leaves the state unchanged.
- R10: When the reference frequency is higher than the feedback frequency, the output spends more cycles driving high than driving low over a long window. The reverse holds when the feedback frequency is higher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset that clears every flop |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| up_flag | output | 1 | Reference-side state flop |
| dn_flag | output | 1 | Feedback-side state flop |
| pd_data | output | 1 | Value placed on the tri-state control pin |
| pd_oe | output | 1 | Output-enable of the control pin; 0 means high impedance |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. This keeps the delay from input to output at three clock edges, so a short square-wave period of four to ten cycles already covers every phase relationship. The bench sweeps every phase offset for equal periods, covering lead, lag and exact alignment. It also runs several unequal period pairs in both directions, which brings in repeated edges on one input and frequency pull-in within a few hundred cycles. Directed runs pin the exact latency and the long-window high/low balance.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;

  typedef enum logic [1:0] {
    PD_FLOAT   = 2'b00,
    PD_DRIVE_H = 2'b01,
    PD_DRIVE_L = 2'b10
  } pd_mode_e;

  localparam int unsigned PFD_NUM_INPUTS = 2;
  localparam int unsigned PFD_IDX_REF    = 0;
  localparam int unsigned PFD_IDX_FB     = 1;

endpackage

// File: rtl/pfd_edge_sampler.sv
module pfd_edge_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[LAST];
    end
  end

  assign rise = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_rise,
  input  logic       fb_rise,
  output pfd_state_t state
);

  pfd_state_t state_q;
  pfd_state_t state_d;
  logic       want_up;
  logic       want_dn;

  always_comb begin
    want_up = state_q.up | ref_rise;
    want_dn = state_q.dn | fb_rise;
    if (want_up && want_dn) begin
      state_d = '0;
    end else begin
      state_d.up = want_up;
      state_d.dn = want_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/pfd_drive_stage.sv
module pfd_drive_stage
  import pfd_pkg::*;
(
  input  pfd_state_t state,
  output logic       pd_data,
  output logic       pd_oe
);

  pd_mode_e mode;

  always_comb begin
    unique case ({state.up, state.dn})
      2'b10:   mode = PD_DRIVE_H;
      2'b01:   mode = PD_DRIVE_L;
      default: mode = PD_FLOAT;
    endcase
  end

  assign pd_oe   = (mode != PD_FLOAT);
  assign pd_data = (mode == PD_DRIVE_H);

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_flag,
  output logic dn_flag,
  output logic pd_data,
  output logic pd_oe
);

  logic [PFD_NUM_INPUTS-1:0] raw_vec;
  logic [PFD_NUM_INPUTS-1:0] rise_vec;
  logic                      ref_rise;
  logic                      fb_rise;
  pfd_state_t                state;

  assign raw_vec[PFD_IDX_REF] = ref_in;
  assign raw_vec[PFD_IDX_FB]  = fb_in;

  for (genvar g = 0; g < PFD_NUM_INPUTS; g++) begin : g_sampler
    pfd_edge_sampler #(
      .STAGES(SYNC_STAGES)
    ) sampler_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_vec[g]),
      .rise (rise_vec[g])
    );
  end

  assign ref_rise = rise_vec[PFD_IDX_REF];
  assign fb_rise  = rise_vec[PFD_IDX_FB];

  pfd_state_core core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .state   (state)
  );

  pfd_drive_stage drive_i (
    .state  (state),
    .pd_data(pd_data),
    .pd_oe  (pd_oe)
  );

  assign up_flag = state.up;
  assign dn_flag = state.dn;

endmodule

// File: rtl/pfd_tristate_checker.sv
module pfd_tristate_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_rise,
  input logic fb_rise,
  input logic up_flag,
  input logic dn_flag,
  input logic pd_data,
  input logic pd_oe
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $past(!rst_n) |-> (!up_flag && !dn_flag && !pd_oe)); // R1
  AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n) (ref_rise && !fb_rise && !dn_flag) |=> (up_flag && pd_oe && pd_data)); // R2
  AST_DN_SET: assert property (@(posedge clk) disable iff (!rst_n) (fb_rise && !ref_rise && !up_flag) |=> (dn_flag && pd_oe && !pd_data)); // R3
  AST_CROSS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ((ref_rise && dn_flag) || (fb_rise && up_flag)) |=> (!up_flag && !dn_flag && !pd_oe)); // R4
  AST_ALIGNED_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) (ref_rise && fb_rise && !up_flag && !dn_flag) |=> (!up_flag && !dn_flag)); // R5
  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ref_rise && !fb_rise) |=> ($stable(up_flag) && $stable(dn_flag))); // R6
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(up_flag && dn_flag)); // R8
  AST_OE_DATA: assert property (@(posedge clk) disable iff (!rst_n) (pd_oe == (up_flag || dn_flag)) && (!pd_oe || (pd_data == up_flag))); // R8
  AST_REPEAT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (ref_rise && !fb_rise && up_flag) |=> (up_flag && !dn_flag)); // R9

endmodule

bind pfd_tristate pfd_tristate_checker checker_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_rise(ref_rise),
  .fb_rise (fb_rise),
  .up_flag (up_flag),
  .dn_flag (dn_flag),
  .pd_data (pd_data),
  .pd_oe   (pd_oe)
);

// File: tb/pfd_tristate_tb_top.sv
`timescale 1ns/1ps
module pfd_tristate_tb_top;

  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic up_flag, dn_flag, pd_data, pd_oe;

  int checks = 0;
  int errors = 0;
  int m = 0;
  bit hr [0:31];
  bit hf [0:31];
  bit exp_up = 1'b0;
  bit exp_dn = 1'b0;

  always #2.5 clk = ~clk;

  pfd_tristate #(.SYNC_STAGES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .up_flag(up_flag), .dn_flag(dn_flag), .pd_data(pd_data), .pd_oe(pd_oe)
  );

  function automatic bit hist(bit is_ref, int idx);
    if (idx < 0) return 1'b0;
    return is_ref ? hr[idx % 32] : hf[idx % 32];
  endfunction

  task automatic check_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at step %0d", tag, what, act, exp, m);
    end
  endtask

  task automatic check_all(string tag);
    check_bit(tag, "up_flag", up_flag, exp_up);
    check_bit(tag, "dn_flag", dn_flag, exp_dn);
    check_bit("R8", "pd_oe", pd_oe, exp_up | exp_dn);
    check_bit("R8", "pd_data", pd_oe ? pd_data : exp_up, exp_up);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1", "up_flag in reset", up_flag, 1'b0);
    check_bit("R1", "pd_oe in reset", pd_oe, 1'b0);
    rst_n = 1'b1;
    m = 0; exp_up = 1'b0; exp_dn = 1'b0;
    for (int i = 0; i < 32; i++) begin hr[i] = 1'b0; hf[i] = 1'b0; end
  endtask

  // Drive one cycle of input levels, advance one clock, check outputs.
  task automatic step(bit r, bit f);
    bit rr, fr, su, sd;
    string tag;
    hr[m % 32] = r; hf[m % 32] = f;
    ref_in = r; fb_in = f;
    @(posedge clk);
    rr = hist(1'b1, m - S) & ~hist(1'b1, m - S - 1);
    fr = hist(1'b0, m - S) & ~hist(1'b0, m - S - 1);
    su = exp_up | rr;
    sd = exp_dn | fr;
    if (rr && fr && !exp_up && !exp_dn) tag = "R5";
    else if (su && sd) tag = "R4";
    else if (!rr && !fr) tag = "R6";
    else if ((rr && exp_up) || (fr && exp_dn)) tag = "R9";
    else if (rr) tag = "R2";
    else tag = "R3";
    if (su && sd) begin exp_up = 1'b0; exp_dn = 1'b0; end
    else begin exp_up = su; exp_dn = sd; end
    m++;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic run_waves(int pr, int pf, int offr, int offf, int cycles);
    for (int c = 0; c < cycles; c++)
      step(((c + offr) % pr) < (pr / 2), ((c + offf) % pf) < (pf / 2));
  endtask

  task automatic balance(int pr, int pf, bit expect_high);
    int hi_cnt = 0;
    int lo_cnt = 0;
    do_reset();
    for (int c = 0; c < 300; c++) begin
      step((c % pr) < (pr / 2), (c % pf) < (pf / 2));
      if (pd_oe && pd_data) hi_cnt++;
      if (pd_oe && !pd_data) lo_cnt++;
    end
    checks++;
    if ((hi_cnt > lo_cnt) != expect_high) begin
      errors++;
      $display("FAIL R10 high=%0d low=%0d actual_high_wins=%b expected=%b",
               hi_cnt, lo_cnt, hi_cnt > lo_cnt, expect_high);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: first cycle after release
    check_bit("R1", "up_flag after release", up_flag, 1'b0);
    check_bit("R1", "dn_flag after release", dn_flag, 1'b0);
    check_bit("R1", "pd_oe after release", pd_oe, 1'b0);

    // R7: exact latency of a reference rise
    do_reset();
    begin
      int seen = -1;
      for (int k = 0; k < 6; k++) begin
        step(1'b1, 1'b0);
        if (seen < 0 && up_flag) seen = k;
      end
      checks++;
      if (seen != S) begin
        errors++;
        $display("FAIL R7 latency actual=%0d expected=%0d", seen, S);
      end
    end
    // R6: falling edge of reference leaves state set
    run_waves(1000, 1000, 500, 500, 6);
    check_bit("R6", "up_flag after ref fall", up_flag, 1'b1);
    // R4: feedback rise then clears
    run_waves(1000, 1000, 500, 0, 6);
    check_bit("R4", "pd_oe after clear", pd_oe, 1'b0);

    // Equal periods, every phase offset (R2, R3, R4, R5)
    for (int p = 4; p <= 8; p += 4)
      for (int o = 0; o < p; o++) begin
        do_reset();
        run_waves(p, p, 0, o, 64);
      end
    // Unequal periods both ways (R9, frequency error)
    do_reset(); run_waves(6, 8, 0, 0, 96);
    do_reset(); run_waves(8, 6, 0, 3, 96);
    do_reset(); run_waves(4, 10, 1, 0, 96);
    do_reset(); run_waves(10, 4, 0, 2, 96);

    balance(6, 10, 1'b1); // R10
    balance(10, 6, 1'b0); // R10

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule